// File: doc/BRIEF.md
# Monitor Channel Byte Transmitter

This block feeds the monitor channel of a time-division serial link, one byte per transfer. A host fills a single 16-bit transmit descriptor; on every frame slot, marked by a one-cycle strobe, the block presents the monitor data byte, the outgoing E bit and the outgoing A bit. It also samples the A bit that arrives from the far end. Framing, serialisation and the command/indicate channel belong to other blocks.

Two modes exist. In handshaked mode the block marks a new byte with a single low E slot. It waits for the far end to pull A low, then hands the descriptor back to the host by clearing the ready flag. A byte flagged as last is followed by an end-of-message slot. If A stays high for two slots in a row, the block treats it as an abort: it flags the abort in the descriptor and closes with an end-of-message slot. In transparent mode the host drives the outgoing A and E bits through two descriptor fields, and a ready byte is released at the next slot without any acknowledge. When no new byte is ready, the previous byte is repeated.

Top module: `mchan_byte_tx`

## Requirements
- R1: After reset the descriptor reads 0x0000, tx_data is 0xFF and tx_e and tx_a are both 1.
- R2: Descriptor bits 12 to 10 always read 0, whatever the host writes into them.
- R3: In handshaked mode, a slot that finds ready (bit 15) set while the block is idle makes tx_data equal the descriptor byte (bits 7..0) and tx_e equal 0. At the following slot tx_e returns to 1.
- R4: In handshaked mode, ready stays set until the far end drives a_in low at a slot of a byte in flight. The descriptor then shows ready clear after that slot.
- R5: A slot that finds no ready descriptor repeats the previous tx_data and drives tx_e high.
- R6: When an acknowledged byte had last (bit 14) set, the next slot is an end-of-message slot with tx_e high. A newly readied byte starts only at the slot after that.
- R7: In handshaked mode, a_in high at two consecutive slots of a byte in flight sets abort (bit 13), clears ready and is followed by one end-of-message slot with tx_e high.
- R8: In transparent mode, each slot copies bit 9 to tx_a and bit 8 to tx_e. A ready byte is sent at the next slot and ready is cleared there without an acknowledge. Last, abort detection and a_in have no effect.
- R9: In handshaked mode, bits 9 and 8 have no effect and tx_a stays 1.
- R10: A host write in the same cycle as the block clearing ready or setting abort takes precedence, so the written value is stored.
- R11: tx_data, tx_e and tx_a change only on the clock edge that samples a slot strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_tr | input | 1 | 1 selects transparent mode, 0 selects handshaked mode |
| wr_en | input | 1 | Host write strobe for the descriptor |
| wr_data | input | 16 | Descriptor value written by the host |
| desc_q | output | 16 | Current descriptor contents |
| slot_stb | input | 1 | One-cycle marker of a monitor slot |
| a_in | input | 1 | A bit received from the far end |
| tx_data | output | 8 | Monitor byte for the current slot |
| tx_e | output | 1 | Outgoing E bit |
| tx_a | output | 1 | Outgoing A bit |

## Verification
Every result is due one clock after the edge that samples a slot strobe. The outputs and any block change to the descriptor appear on that edge. A host write shows in the descriptor one clock after its strobe. The bench raises the strobe for exactly one cycle. The driver queues the outputs it expects for that slot, and the monitor compares them at the falling edge after the slot edge. Descriptor readbacks and checks that outputs hold between slots are also sampled on falling edges, so no comparison shares an edge with a change.

// File: rtl/mchan_pkg.sv
package mchan_pkg;
  localparam int DESC_W  = 16;
  localparam int DATA_W  = 8;
  localparam int B_RDY   = 15;
  localparam int B_LAST  = 14;
  localparam int B_ABRT  = 13;
  localparam int B_AVAL  = 9;
  localparam int B_EVAL  = 8;
  localparam logic [DESC_W-1:0] HOST_MASK = 16'hE3FF;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_EOM} hs_state_t;

  // host value as stored: reserved field forced to zero
  function automatic logic [DESC_W-1:0] host_clean(input logic [DESC_W-1:0] w);
    return w & HOST_MASK;
  endfunction

  // outgoing E in handshaked mode: low only on the slot that opens a byte
  function automatic logic hs_e_bit(input logic opening);
    return ~opening;
  endfunction
endpackage

// File: rtl/mchan_desc_reg.sv
module mchan_desc_reg
  import mchan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DESC_W-1:0] wr_data,
  input  logic              clr_rdy,
  input  logic              set_abrt,
  output logic [DESC_W-1:0] desc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc <= '0;
    end else if (wr_en) begin
      desc <= host_clean(wr_data);
    end else begin
      if (clr_rdy)  desc[B_RDY]  <= 1'b0;
      if (set_abrt) desc[B_ABRT] <= 1'b1;
    end
  end
endmodule

// File: rtl/mchan_a_watch.sv
module mchan_a_watch #(
  parameter int ABORT_SLOTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_stb,
  input  logic armed,
  input  logic a_in,
  output logic ack_ev,
  output logic abort_ev
);
  localparam int CNT_W = $clog2(ABORT_SLOTS + 1);
  localparam logic [CNT_W-1:0] HI_LIMIT = CNT_W'(ABORT_SLOTS - 1);

  logic [CNT_W-1:0] hi_cnt;

  assign ack_ev   = slot_stb & armed & ~a_in;
  assign abort_ev = slot_stb & armed & a_in & (hi_cnt == HI_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (!armed || ack_ev || abort_ev) begin
      hi_cnt <= '0;
    end else if (slot_stb && a_in) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mchan_tx_core.sv
module mchan_tx_core
  import mchan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_stb,
  input  logic              mode_tr,
  input  logic [DESC_W-1:0] desc,
  input  logic              ack_ev,
  input  logic              abort_ev,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_e,
  output logic              tx_a,
  output logic              clr_rdy,
  output logic              set_abrt,
  output logic              armed,
  output logic              hs_start
);
  hs_state_t state, state_nx;
  logic      last_q;
  logic      tr_start;

  assign armed    = (state == ST_WAIT) & ~mode_tr;
  assign hs_start = slot_stb & ~mode_tr & desc[B_RDY] & (state == ST_IDLE);
  assign tr_start = slot_stb & mode_tr & desc[B_RDY];
  assign clr_rdy  = tr_start | ack_ev | abort_ev;
  assign set_abrt = abort_ev;

  always_comb begin
    state_nx = state;
    if (mode_tr) begin
      state_nx = ST_IDLE;
    end else if (slot_stb) begin
      case (state)
        ST_IDLE: if (desc[B_RDY]) state_nx = ST_WAIT;
        ST_WAIT: begin
          if (abort_ev)    state_nx = ST_EOM;
          else if (ack_ev) state_nx = last_q ? ST_EOM : ST_IDLE;
        end
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      last_q  <= 1'b0;
      tx_data <= '1;
      tx_e    <= 1'b1;
      tx_a    <= 1'b1;
    end else begin
      state <= state_nx;
      if (hs_start) last_q <= desc[B_LAST];
      if (slot_stb) begin
        if (hs_start || tr_start) tx_data <= desc[DATA_W-1:0];
        if (mode_tr) begin
          tx_e <= desc[B_EVAL];
          tx_a <= desc[B_AVAL];
        end else begin
          tx_e <= hs_e_bit(hs_start);
          tx_a <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mchan_byte_tx.sv
module mchan_byte_tx
  import mchan_pkg::*;
#(
  parameter int ABORT_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_tr,
  input  logic              wr_en,
  input  logic [DESC_W-1:0] wr_data,
  output logic [DESC_W-1:0] desc_q,
  input  logic              slot_stb,
  input  logic              a_in,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_e,
  output logic              tx_a
);
  logic clr_rdy, set_abrt, armed, hs_start, ack_ev, abort_ev;

  mchan_desc_reg u_desc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clr_rdy(clr_rdy), .set_abrt(set_abrt), .desc(desc_q)
  );

  mchan_a_watch #(.ABORT_SLOTS(ABORT_SLOTS)) u_watch (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .armed(armed),
    .a_in(a_in), .ack_ev(ack_ev), .abort_ev(abort_ev)
  );

  mchan_tx_core u_core (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .mode_tr(mode_tr),
    .desc(desc_q), .ack_ev(ack_ev), .abort_ev(abort_ev),
    .tx_data(tx_data), .tx_e(tx_e), .tx_a(tx_a), .clr_rdy(clr_rdy),
    .set_abrt(set_abrt), .armed(armed), .hs_start(hs_start)
  );
endmodule

// File: rtl/mchan_byte_tx_chk.sv
module mchan_byte_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_tr,
  input logic        wr_en,
  input logic        slot_stb,
  input logic [15:0] desc_q,
  input logic [7:0]  tx_data,
  input logic        tx_e,
  input logic        tx_a,
  input logic        hs_start,
  input logic        abort_ev
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    desc_q[12:10] == 3'b000); // R2

  AST_HS_START_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_start |=> (tx_data == $past(desc_q[7:0])) && !tx_e); // R3

  AST_RDY_CLR_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(desc_q[15]) && !$past(wr_en)) |-> $past(slot_stb)); // R4

  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ev && !wr_en) |=> desc_q[13] && !desc_q[15]); // R7

  AST_TA_HIGH_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && !mode_tr) |=> tx_a); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> $stable(tx_data) && $stable(tx_e) && $stable(tx_a)); // R11
endmodule

bind mchan_byte_tx mchan_byte_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_tr(mode_tr), .wr_en(wr_en),
  .slot_stb(slot_stb), .desc_q(desc_q), .tx_data(tx_data), .tx_e(tx_e),
  .tx_a(tx_a), .hs_start(hs_start), .abort_ev(abort_ev)
);

// File: tb/mchan_byte_tx_tb.sv
module mchan_byte_tx_tb;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0, rst_n = 1'b0, mode_tr = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        slot_stb = 1'b0, a_in = 1'b1;
  logic [15:0] desc_q;
  logic [7:0]  tx_data;
  logic        tx_e, tx_a;

  int n_cmp = 0, n_bad = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic       chk_next = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  mchan_byte_tx u_dut (
    .clk(clk), .rst_n(rst_n), .mode_tr(mode_tr), .wr_en(wr_en),
    .wr_data(wr_data), .desc_q(desc_q), .slot_stb(slot_stb), .a_in(a_in),
    .tx_data(tx_data), .tx_e(tx_e), .tx_a(tx_a)
  );

  function automatic void check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  // monitor: compares the slot result one clock after the slot edge
  always @(posedge clk) chk_next <= slot_stb;
  always @(negedge clk) begin
    if (chk_next) begin
      if (exp_q.size() == 0) check("queue", 16'h1, 16'h0);
      else check(tag_q.pop_front(), {6'd0, tx_data, tx_e, tx_a}, {6'd0, exp_q.pop_front()});
    end
  end

  task automatic host_wr(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic slot(input logic a, input logic [7:0] d, input logic e, input logic ta,
                      input string tag, input logic with_wr = 1'b0,
                      input logic [15:0] wv = '0);
    @(negedge clk);
    a_in = a; slot_stb = 1'b1;
    wr_en = with_wr; wr_data = wv;
    exp_q.push_back({d, e, ta}); tag_q.push_back(tag);
    @(negedge clk);
    slot_stb = 1'b0; wr_en = 1'b0; a_in = 1'b1;
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 desc", desc_q, 16'h0000);
    check("R1 outs", {6'd0, tx_data, tx_e, tx_a}, {6'd0, 8'hFF, 1'b1, 1'b1});
    rst_n = 1'b1;
    slot(1'b1, 8'hFF, 1'b1, 1'b1, "R5 idle repeat after reset");

    // reserved bits dropped, A/E fields ignored in handshaked mode
    host_wr(16'h9F3C);
    check("R2 reserved", desc_q, 16'h833C);
    slot(1'b1, 8'h3C, 1'b0, 1'b1, "R3 R9 start byte");
    check("R4 ready held", desc_q, 16'h833C);
    slot(1'b0, 8'h3C, 1'b1, 1'b1, "R3 E back high");
    check("R4 ready cleared on ack", desc_q, 16'h033C);
    slot(1'b1, 8'h3C, 1'b1, 1'b1, "R5 stale repeat");

    // last byte: extra end-of-message slot
    host_wr(16'hC0A5);
    slot(1'b1, 8'hA5, 1'b0, 1'b1, "R3 last byte start");
    slot(1'b0, 8'hA5, 1'b1, 1'b1, "R6 last ack");
    check("R6 desc after ack", desc_q, 16'h40A5);
    host_wr(16'h8011);
    slot(1'b1, 8'hA5, 1'b1, 1'b1, "R6 eom slot");
    check("R6 ready waits", desc_q, 16'h8011);
    slot(1'b1, 8'h11, 1'b0, 1'b1, "R6 next byte after eom");
    slot(1'b0, 8'h11, 1'b1, 1'b1, "R4 ack");
    check("R4 cleared", desc_q, 16'h0011);

    // abort: A high at two consecutive slots
    host_wr(16'h8077);
    slot(1'b1, 8'h77, 1'b0, 1'b1, "R7 byte start");
    slot(1'b1, 8'h77, 1'b1, 1'b1, "R7 first high");
    check("R7 no abort yet", desc_q, 16'h8077);
    slot(1'b1, 8'h77, 1'b1, 1'b1, "R7 abort slot");
    check("R7 abort flagged", desc_q, 16'h2077);
    host_wr(16'h8088);
    slot(1'b1, 8'h77, 1'b1, 1'b1, "R7 eom after abort");
    slot(1'b1, 8'h88, 1'b0, 1'b1, "R7 resume");
    slot(1'b0, 8'h88, 1'b1, 1'b1, "R4 ack after resume");
    check("R4 cleared 88", desc_q, 16'h0088);

    // collision: host write in the ack cycle wins
    host_wr(16'h8099);
    slot(1'b1, 8'h99, 1'b0, 1'b1, "R3 byte 99");
    slot(1'b0, 8'h99, 1'b1, 1'b1, "R10 ack with write", 1'b1, 16'h80AA);
    check("R10 host wins", desc_q, 16'h80AA);
    slot(1'b1, 8'hAA, 1'b0, 1'b1, "R10 written byte sent");
    slot(1'b0, 8'hAA, 1'b1, 1'b1, "R4 ack AA");
    check("R4 cleared AA", desc_q, 16'h00AA);

    // outputs hold between slots
    host_wr(16'h83CD);
    a_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 hold", {6'd0, tx_data, tx_e, tx_a}, {6'd0, 8'hAA, 1'b1, 1'b1});
    host_wr(16'h0000);

    // transparent mode
    mode_tr = 1'b1;
    host_wr(16'hC2B4);
    slot(1'b1, 8'hB4, 1'b0, 1'b1, "R8 fields to E/A");
    check("R8 ready cleared no ack", desc_q, 16'h42B4);
    host_wr(16'h0155);
    slot(1'b1, 8'hB4, 1'b1, 1'b0, "R8 fields swap");
    slot(1'b1, 8'hB4, 1'b1, 1'b0, "R8 A high no abort");
    check("R8 no abort flag", desc_q, 16'h0155);
    mode_tr = 1'b0;
    slot(1'b1, 8'hB4, 1'b1, 1'b1, "R9 back to handshaked");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule